// File: doc/BRIEF.md
# Host Register and Shared Data Bus Interface

This block sits between a host processor and an avionics serial terminal. It holds the 16-bit configuration register that the host writes through the shared data bus. It collects the FIFO flags of two receive channels and one transmit channel into a 9-bit status word. It also decides, every clock cycle, what the shared 16-bit bus carries: the status word, the configuration register, one half of the word at the head of a receive channel, or nothing.

The host reads a 32-bit receive word in two bus cycles. The half-select input picks the low half at 0 and the high half at 1. When both receive enables are active, channel 0 wins. A register read beats any receive read. The bus is returned to high impedance whenever no read is requested. The receive words arrive already arranged by the datapath. Bit 15 of the configuration register tells the datapath which arrangement to use: 1 means unscrambled, 0 means scrambled. This block only selects halves and never permutes bits.

The bus outputs are registered. A decision made from the inputs sampled at one rising edge appears on `data_out` and `data_oe` right after that edge. The data bus is split into `data_in`, `data_out` and an output enable. A pad ring or wrapper turns these into the tri-state pins.

Top module: `host_regif`

## Requirements
- R1: While `rst_n` is low, `ctrl` is 0, `data_oe` is 0 and `fifo_clr` is 1. `fifo_clr` falls at the first rising edge after `rst_n` returns high.
- R2: `ctrl` takes the value of `data_in` at the first rising edge where `cw_wr_n` is sampled low after having been sampled high. Holding `cw_wr_n` low does not load again, and `ctrl` never changes while `cw_wr_n` is sampled high.
- R3: With `rd_reg_n` low and `sel` at 1, the edge drives `data_out` = `ctrl` and `data_oe` = 1.
- R4: With `rd_reg_n` low and `sel` at 0, the edge drives `data_out[8:0]` with the status word, drives `data_out[15:9]` = 0, and sets `data_oe` = 1. The status bits are:
  - bit 0: channel 0 ready; bit 1: channel 0 half; bit 2: channel 0 full
  - bit 3: channel 1 ready; bit 4: channel 1 half; bit 5: channel 1 full
  - bit 6: tx empty; bit 7: tx full; bit 8: tx half
- R5: The `status` output carries the same 9-bit word, registered from the flags sampled at each edge.
- R6: With `rd_reg_n` high and `rx_en_n[0]` low, the edge drives channel 0's word onto the bus with `data_oe` = 1. `sel` = 0 gives bits 15:0 and `sel` = 1 gives bits 31:16. This holds whatever the level of `rx_en_n[1]`.
- R7: Channel 1's word, halved by `sel` in the same way, is driven only when `rx_en_n[1]` is low while `rx_en_n[0]` is high and `rd_reg_n` is high.
- R8: A register read (`rd_reg_n` low) takes priority over any receive enable.
- R9: When `rd_reg_n` and both receive enables are high, the edge sets `data_oe` = 0 and `data_out` = 0.
- R10: A receive read returns the same halves whatever the value of `ctrl[15]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| data_in | input | 16 | Bus value driven by the host |
| cw_wr_n | input | 1 | Active-low configuration write strobe |
| rd_reg_n | input | 1 | Active-low register read strobe |
| sel | input | 1 | Register choice (0 status, 1 config) or word half (0 low, 1 high) |
| rx_en_n | input | 2 | Active-low receive read enables, index 0 has priority |
| rx_word | input | 64 | Head-of-FIFO word of each receive channel, 32 bits each |
| rx_ready | input | 2 | Receive FIFO holds data, per channel |
| rx_half | input | 2 | Receive FIFO at least half full, per channel |
| rx_full | input | 2 | Receive FIFO full, per channel |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_half | input | 1 | Transmit FIFO at least half full |
| data_out | output | 16 | Value the block drives onto the bus |
| data_oe | output | 1 | Bus drive enable, 0 means high impedance |
| ctrl | output | 16 | Configuration register, bit 15 selects the word arrangement |
| status | output | 9 | Registered status word |
| fifo_clr | output | 1 | Clears all three FIFOs during and just after reset |

## Verification
Several rules are checked on every cycle by assertions:
- a configuration write lands only on a falling strobe, and the register holds while the strobe is high;
- each kind of read puts the right source on the bus;
- channel 0 wins a receive read;
- the bus drops to high impedance when idle.

Some behaviour only the bench scenarios can show:
- the exact bit placement of the status flags under distinct flag patterns;
- that a held write strobe does not reload;
- that a register read outranks a receive read;
- that reset, including one applied in mid-operation, clears the register and raises the FIFO clear;
- that the configuration format bit leaves receive halves unchanged.

// File: rtl/hif_pkg.sv
`timescale 1ns/1ps
package hif_pkg;
    parameter int HIF_DATA_W = 16;
    parameter int HIF_N_RX   = 2;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_CTRL   = 2'd2,
        SRC_RX     = 2'd3
    } hif_src_e;
endpackage

// File: rtl/hif_ctrl_reg.sv
`timescale 1ns/1ps
module hif_ctrl_reg #(
    parameter int DATA_W = hif_pkg::HIF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] ctrl,
    output logic              fifo_clr
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              strobe_prev;
        logic              clr;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = cw_wr_n;
        st_d.clr         = 1'b0;
        if (st_q.strobe_prev && !cw_wr_n) begin
            st_d.word = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word        <= '0;
            st_q.strobe_prev <= 1'b1;
            st_q.clr         <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.word;
    assign fifo_clr = st_q.clr;
endmodule

// File: rtl/hif_status.sv
`timescale 1ns/1ps
module hif_status #(
    parameter int N_RX   = hif_pkg::HIF_N_RX,
    parameter int STAT_W = 3 * N_RX + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RX-1:0]   rx_ready,
    input  logic [N_RX-1:0]   rx_half,
    input  logic [N_RX-1:0]   rx_full,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              tx_half,
    output logic [STAT_W-1:0] status_now,
    output logic [STAT_W-1:0] status
);
    localparam int TX_BASE = 3 * N_RX;

    typedef struct packed {
        logic [STAT_W-1:0] word;
    } stat_state_t;

    stat_state_t st_d, st_q;

    for (genvar ch = 0; ch < N_RX; ch++) begin : g_rx_flags
        assign status_now[3*ch]     = rx_ready[ch];
        assign status_now[3*ch + 1] = rx_half[ch];
        assign status_now[3*ch + 2] = rx_full[ch];
    end
    assign status_now[TX_BASE]     = tx_empty;
    assign status_now[TX_BASE + 1] = tx_full;
    assign status_now[TX_BASE + 2] = tx_half;

    always_comb begin
        st_d      = st_q;
        st_d.word = status_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.word;
endmodule

// File: rtl/hif_bus_mux.sv
`timescale 1ns/1ps
module hif_bus_mux
    import hif_pkg::*;
#(
    parameter int DATA_W = HIF_DATA_W,
    parameter int N_RX   = HIF_N_RX,
    parameter int STAT_W = 3 * N_RX + 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_reg_n,
    input  logic                              sel,
    input  logic [N_RX-1:0]                   rx_en_n,
    input  logic [N_RX-1:0][2*DATA_W-1:0]     rx_word,
    input  logic [STAT_W-1:0]                 status_now,
    input  logic [DATA_W-1:0]                 ctrl_now,
    output logic [DATA_W-1:0]                 data_out,
    output logic                              data_oe
);
    localparam int WORD_W = 2 * DATA_W;
    localparam int IDX_W  = (N_RX > 1) ? $clog2(N_RX) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              oe;
    } bus_state_t;

    bus_state_t        st_d, st_q;
    hif_src_e          src;
    logic [IDX_W-1:0]  grant;
    logic [WORD_W-1:0] chosen;

    // Source decode: register read first, then lowest-index receive enable.
    always_comb begin
        src   = SRC_NONE;
        grant = '0;
        if (!rd_reg_n) begin
            src = sel ? SRC_CTRL : SRC_STATUS;
        end else begin
            for (int i = 0; i < N_RX; i++) begin
                if (src == SRC_NONE && !rx_en_n[i]) begin
                    src   = SRC_RX;
                    grant = IDX_W'(i);
                end
            end
        end
    end

    assign chosen = rx_word[grant];

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_STATUS: begin
                st_d.data = DATA_W'(status_now);
                st_d.oe   = 1'b1;
            end
            SRC_CTRL: begin
                st_d.data = ctrl_now;
                st_d.oe   = 1'b1;
            end
            SRC_RX: begin
                st_d.data = sel ? chosen[WORD_W-1:DATA_W] : chosen[DATA_W-1:0];
                st_d.oe   = 1'b1;
            end
            default: begin
                st_d.data = '0;
                st_d.oe   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.data;
    assign data_oe  = st_q.oe;
endmodule

// File: rtl/host_regif.sv
`timescale 1ns/1ps
module host_regif
    import hif_pkg::*;
#(
    parameter int DATA_W = HIF_DATA_W,
    parameter int N_RX   = HIF_N_RX,
    parameter int STAT_W = 3 * N_RX + 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             data_in,
    input  logic                          cw_wr_n,
    input  logic                          rd_reg_n,
    input  logic                          sel,
    input  logic [N_RX-1:0]               rx_en_n,
    input  logic [N_RX-1:0][2*DATA_W-1:0] rx_word,
    input  logic [N_RX-1:0]               rx_ready,
    input  logic [N_RX-1:0]               rx_half,
    input  logic [N_RX-1:0]               rx_full,
    input  logic                          tx_empty,
    input  logic                          tx_full,
    input  logic                          tx_half,
    output logic [DATA_W-1:0]             data_out,
    output logic                          data_oe,
    output logic [DATA_W-1:0]             ctrl,
    output logic [STAT_W-1:0]             status,
    output logic                          fifo_clr
);
    logic [STAT_W-1:0] status_now;

    hif_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_wr_n  (cw_wr_n),
        .data_in  (data_in),
        .ctrl     (ctrl),
        .fifo_clr (fifo_clr)
    );

    hif_status #(.N_RX(N_RX), .STAT_W(STAT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_ready   (rx_ready),
        .rx_half    (rx_half),
        .rx_full    (rx_full),
        .tx_empty   (tx_empty),
        .tx_full    (tx_full),
        .tx_half    (tx_half),
        .status_now (status_now),
        .status     (status)
    );

    hif_bus_mux #(.DATA_W(DATA_W), .N_RX(N_RX), .STAT_W(STAT_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_reg_n   (rd_reg_n),
        .sel        (sel),
        .rx_en_n    (rx_en_n),
        .rx_word    (rx_word),
        .status_now (status_now),
        .ctrl_now   (ctrl),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );
endmodule

// File: rtl/hif_checker.sv
`timescale 1ns/1ps
module hif_checker #(
    parameter int DATA_W = 16,
    parameter int N_RX   = 2,
    parameter int STAT_W = 3 * N_RX + 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [DATA_W-1:0]             data_in,
    input logic                          cw_wr_n,
    input logic                          rd_reg_n,
    input logic                          sel,
    input logic [N_RX-1:0]               rx_en_n,
    input logic [N_RX-1:0][2*DATA_W-1:0] rx_word,
    input logic [DATA_W-1:0]             data_out,
    input logic                          data_oe,
    input logic [DATA_W-1:0]             ctrl,
    input logic [STAT_W-1:0]             status
);
    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cw_wr_n) |=> ctrl == $past(data_in));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr_n |=> $stable(ctrl));

    // R3
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_reg_n && sel) |=> (data_oe && data_out == $past(ctrl)));

    // R4
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_reg_n && !sel) |=> (data_oe && data_out == DATA_W'(status)));

    // R6
    rx_first_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg_n && !rx_en_n[0] && !sel) |=>
            (data_oe && data_out == $past(rx_word[0][DATA_W-1:0])));

    // R6
    rx_first_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg_n && !rx_en_n[0] && sel) |=>
            (data_oe && data_out == $past(rx_word[0][2*DATA_W-1:DATA_W])));

    // R7
    rx_second_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg_n && rx_en_n[0] && !rx_en_n[N_RX-1] && sel) |=>
            (data_oe && data_out == $past(rx_word[N_RX-1][2*DATA_W-1:DATA_W])));

    // R9
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg_n && &rx_en_n) |=> (!data_oe && data_out == '0));
endmodule

bind host_regif hif_checker #(.DATA_W(DATA_W), .N_RX(N_RX), .STAT_W(STAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (data_in),
    .cw_wr_n  (cw_wr_n),
    .rd_reg_n (rd_reg_n),
    .sel      (sel),
    .rx_en_n  (rx_en_n),
    .rx_word  (rx_word),
    .data_out (data_out),
    .data_oe  (data_oe),
    .ctrl     (ctrl),
    .status   (status)
);

// File: tb/host_regif_test.sv
`timescale 1ns/1ps
module host_regif_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      data_in = '0;
    logic             cw_wr_n = 1'b1;
    logic             rd_reg_n = 1'b1;
    logic             sel = 1'b0;
    logic [1:0]       rx_en_n = 2'b11;
    logic [1:0][31:0] rx_word = '0;
    logic [1:0]       rx_ready = '0, rx_half = '0, rx_full = '0;
    logic             tx_empty = 1'b0, tx_full = 1'b0, tx_half = 1'b0;
    logic [15:0]      data_out, ctrl;
    logic             data_oe, fifo_clr;
    logic [8:0]       status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    host_regif uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .cw_wr_n(cw_wr_n),
        .rd_reg_n(rd_reg_n), .sel(sel), .rx_en_n(rx_en_n), .rx_word(rx_word),
        .rx_ready(rx_ready), .rx_half(rx_half), .rx_full(rx_full),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_half(tx_half),
        .data_out(data_out), .data_oe(data_oe), .ctrl(ctrl),
        .status(status), .fifo_clr(fifo_clr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Status layout per R4: rx0 ready/half/full, rx1 same, tx empty/full/half.
    function automatic logic [8:0] expect_status();
        return {tx_half, tx_full, tx_empty,
                rx_full[1], rx_half[1], rx_ready[1],
                rx_full[0], rx_half[0], rx_ready[0]};
    endfunction

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic write_ctrl(logic [15:0] v);
        @(negedge clk);
        data_in = v;
        cw_wr_n = 1'b0;
        after_edge();
        check("R2 load", ctrl, v);
        @(negedge clk);
        cw_wr_n = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 ctrl in reset", ctrl, 16'h0);
        check("R1 oe in reset", data_oe, 1'b0);
        check("R1 fifo_clr in reset", fifo_clr, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        after_edge();
        check("R1 fifo_clr after release", fifo_clr, 1'b0);
        check("R9 idle after reset", {15'd0, data_oe}, 16'h0);
    endtask

    task automatic t_ctrl_write();
        write_ctrl(16'hA5C3);
        // Held-low strobe must not reload (R2)
        @(negedge clk);
        data_in = 16'h1111;
        cw_wr_n = 1'b0;
        after_edge();
        @(negedge clk);
        data_in = 16'h2222;
        after_edge();
        check("R2 held low no reload", ctrl, 16'h1111);
        @(negedge clk);
        cw_wr_n = 1'b1;
        data_in = 16'h3333;
        after_edge();
        check("R2 strobe high holds", ctrl, 16'h1111);
    endtask

    task automatic t_ctrl_read();
        write_ctrl(16'h5E0F);
        @(negedge clk);
        rd_reg_n = 1'b0;
        sel = 1'b1;
        after_edge();
        check("R3 ctrl readback", data_out, 16'h5E0F);
        check("R3 oe", data_oe, 1'b1);
        @(negedge clk);
        rd_reg_n = 1'b1;
        after_edge();
        check("R9 released", {data_oe, data_out}, 17'h0);
    endtask

    task automatic status_pattern(logic [1:0] rdy, logic [1:0] hf, logic [1:0] fl,
                                  logic te, logic tf, logic th);
        @(negedge clk);
        rx_ready = rdy;
        rx_half = hf;
        rx_full = fl;
        tx_empty = te;
        tx_full = tf;
        tx_half = th;
        rd_reg_n = 1'b0;
        sel = 1'b0;
        after_edge();
        check("R4 status on bus", data_out, {7'd0, expect_status()});
        check("R4 oe", data_oe, 1'b1);
        check("R5 status port", status, expect_status());
        @(negedge clk);
        rd_reg_n = 1'b1;
    endtask

    task automatic t_status();
        status_pattern(2'b01, 2'b10, 2'b00, 1'b1, 1'b0, 1'b1);
        check("R4 pattern A literal", status, 9'h151);
        status_pattern(2'b11, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1);
        check("R4 pattern B literal", status, 9'h1FF);
        status_pattern(2'b10, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0);
        check("R4 pattern C literal", status, 9'h0A8);
    endtask

    task automatic rx_read(logic [1:0] en, logic s, logic [15:0] exp, string req);
        @(negedge clk);
        rx_en_n = en;
        sel = s;
        after_edge();
        check(req, data_out, exp);
        check(req, data_oe, 1'b1);
        @(negedge clk);
        rx_en_n = 2'b11;
    endtask

    task automatic t_rx();
        rx_word[0] = 32'hDEAD_BEEF;
        rx_word[1] = 32'h1234_5678;
        rx_read(2'b10, 1'b0, 16'hBEEF, "R6 ch0 low half");
        rx_read(2'b10, 1'b1, 16'hDEAD, "R6 ch0 high half");
        rx_read(2'b00, 1'b1, 16'hDEAD, "R6 ch0 wins both");
        rx_read(2'b01, 1'b0, 16'h5678, "R7 ch1 low half");
        rx_read(2'b01, 1'b1, 16'h1234, "R7 ch1 high half");
    endtask

    task automatic t_priority();
        write_ctrl(16'h0F0F);
        @(negedge clk);
        rx_en_n = 2'b00;
        rd_reg_n = 1'b0;
        sel = 1'b1;
        after_edge();
        check("R8 reg read beats rx", data_out, 16'h0F0F);
        @(negedge clk);
        rd_reg_n = 1'b1;
        rx_en_n = 2'b11;
        after_edge();
        check("R9 idle oe", data_oe, 1'b0);
        check("R9 idle data", data_out, 16'h0);
    endtask

    task automatic t_format();
        write_ctrl(16'h8000);
        check("R10 format bit set", ctrl[15], 1'b1);
        rx_read(2'b10, 1'b0, 16'hBEEF, "R10 low half unscrambled mode");
        rx_read(2'b01, 1'b1, 16'h1234, "R10 high half unscrambled mode");
        write_ctrl(16'h0000);
        rx_read(2'b10, 1'b1, 16'hDEAD, "R10 high half scrambled mode");
    endtask

    task automatic t_mid_reset();
        write_ctrl(16'h1234);
        @(negedge clk);
        rd_reg_n = 1'b0;
        sel = 1'b1;
        #1;
        rst_n = 1'b0;
        #1;
        check("R1 async ctrl clear", ctrl, 16'h0);
        check("R1 async oe clear", data_oe, 1'b0);
        check("R1 async fifo_clr", fifo_clr, 1'b1);
        rd_reg_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        after_edge();
        check("R1 fifo_clr drops", fifo_clr, 1'b0);
    endtask

    initial begin
        t_reset();
        t_ctrl_write();
        t_ctrl_read();
        t_status();
        t_rx();
        t_priority();
        t_format();
        t_mid_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule